// File: doc/BRIEF.md
# Monitor interrupt status and masking controller

This block gathers per-channel window-comparison results from a hardware-monitor measurement sequencer. Each channel has an "above high limit" flag, a "below low limit" flag and an update strobe. When a channel is updated while either flag is set, its bit in one of two 8-bit status banks is set and stays set. A host read of a status bank returns the bank and clears it. The bit then stays clear until the sequencer next updates that channel. Every status update is also copied into a matching read-only mirror bank. A second host can watch the mirror without clearing anything.

A single registered, active-high interrupt output combines three sources, all gated by a global enable:
- the status bits that are not masked;
- five external level-sensitive request pins of mixed polarity, each with its own enable;
- an interrupt-clear command. This command drops the output without touching status. The status path stays silenced until a fresh unmasked event arrives.

The host reaches the block through a plain register bus. It has an address, write data, a write strobe and a read strobe. Read data is combinational.

Top module: `irq_status_ctrl`

## Requirements
- R1: On a cycle where `upd_i[c]` is high, status bit c (bank c/8, bit c%8) is set if `above_i[c]` or `below_i[c]` is high. Flags on channels without a strobe have no effect.
- R2: A status bit, once set, stays set through later in-window updates until the host reads its bank.
- R3: A read strobe on a status bank (bank 0 at 0x41, bank 1 at 0x42) returns the bank's current value in the same cycle. The bank is clear from the next cycle on, and stays clear until a channel in that bank is updated out of window.
- R4: When a status read-clear and an out-of-window update of the same bit fall in one cycle, the bit is set afterwards.
- R5: Mask banks (0x43 and 0x44, same bit order as status) reset to all ones. A set mask bit keeps its status bit from driving `int_o`.
- R6: `int_o` is low whenever the enable bit (bit 0 of the configuration register at 0x40) is clear.
- R7: Writing 1 to bit 3 of 0x40 drops `int_o` one cycle after the write and leaves status unchanged. That bit always reads 0.
- R8: After the clear, `int_o` is raised again only by an update that sets a previously clear, unmasked status bit. Updates to bits already set do not raise it.
- R9: Mirror banks (0x45 and 0x46) take the new value of every updated status bit. Reads and writes do not change them, and they have no effect on `int_o`.
- R10: Request pins 0 to 2 are active low and pins 3 to 4 are active high. Pins 0 to 2 are enabled by bits 4 to 6 of the channel-mode register at 0x47. Pins 3 and 4 are enabled by bits 6 and 7 of the register at 0x4A. An enabled, active pin raises `int_o` within four cycles, and its release lowers `int_o` again because nothing is latched.
- R11: After reset, all status, mirror, enable and configuration bits read 0, mask banks read 0xFF and `int_o` is low.
- R12: `int_o` is registered: after an update sets an unmasked bit with the output enabled, `int_o` is still low in the following cycle and high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (clears a status bank on read) |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| upd_i | input | 16 | Per-channel update strobe from the sequencer |
| above_i | input | 16 | Per-channel result: value above high limit |
| below_i | input | 16 | Per-channel result: value below low limit |
| irq_i | input | 5 | External request pins, mixed polarity |
| int_o | output | 1 | Interrupt output, active high |

## Verification
The hardest case to reach from the ports is a read-clear and an update of the same bit landing in one clock. The bench holds the read strobe on status bank 1 and pulses an out-of-window update on one of its channels within that single bus cycle. It then reads the bank back. A second hard case is the silenced state after an interrupt clear. The bench gets there by first re-updating a bit that is already set, which must not release the output. It then unmasks a fresh bit and updates it, which must release the output.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_BANK = 2;
  localparam int N_CH   = N_BANK * DATA_W;
  localparam int N_IRQ  = 5;
  localparam int SYNC_STAGES = 2;
  localparam logic [N_IRQ-1:0] IRQ_ACT_HI = 5'b11000;

  localparam logic [ADDR_W-1:0] A_CFG1   = 8'h40;
  localparam logic [ADDR_W-1:0] A_STAT0  = 8'h41;
  localparam logic [ADDR_W-1:0] A_MASK0  = 8'h43;
  localparam logic [ADDR_W-1:0] A_MIRR0  = 8'h45;
  localparam logic [ADDR_W-1:0] A_CHMODE = 8'h47;
  localparam logic [ADDR_W-1:0] A_CFG2   = 8'h4A;

  localparam int CFG1_EN_BIT  = 0;
  localparam int CFG1_CLR_BIT = 3;
  localparam int CHMODE_LSB   = 4;  // enables for pins 0..2
  localparam int CFG2_LSB     = 6;  // enables for pins 3..4
  localparam int N_IRQ_LO     = 3;
  localparam int N_IRQ_HI     = N_IRQ - N_IRQ_LO;
endpackage

// File: rtl/irq_ext_in.sv
module irq_ext_in #(
  parameter int N = 5,
  parameter int STAGES = 2,
  parameter logic [N-1:0] ACT_HI = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] sync_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= ~ACT_HI;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  // level equals active polarity, no latching
  assign act_o = (sync_q[STAGES-1] ~^ ACT_HI) & en_i;
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] upd_i,
  input  logic [W-1:0] oor_i,
  input  logic         rd_clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mirr_o,
  output logic         new_o
);
  logic [W-1:0] stat_q, stat_d, mirr_q, mirr_d, base;

  always_comb begin
    base   = stat_q & {W{~rd_clr_i}};
    // update wins over a same-cycle read-clear
    stat_d = base | (upd_i & oor_i);
    mirr_d = (mirr_q & ~upd_i) | (upd_i & stat_d);
  end

  assign new_o = |(upd_i & oor_i & ~stat_q & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mirr_q <= '0;
    end else begin
      stat_q <= stat_d;
      mirr_q <= mirr_d;
    end
  end

  assign stat_o = stat_q;
  assign mirr_o = mirr_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   upd_i,
  input  logic [N_CH-1:0]   above_i,
  input  logic [N_CH-1:0]   below_i,
  input  logic [N_IRQ-1:0]  irq_i,
  output logic              int_o
);
  logic [N_CH-1:0]   stat_all, mirr_all, mask_q;
  logic [N_BANK-1:0] bank_new;
  logic [N_IRQ-1:0]  irq_en_q, irq_act;
  logic              int_en_q, hold_q, hold_d, clr_wr, new_evt;
  logic              irq_pend, stat_pend, int_q;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic rd_clr;
    assign rd_clr = re_i && (addr_i == ADDR_W'(A_STAT0 + b));

    irq_stat_bank #(.W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (upd_i[b*DATA_W +: DATA_W]),
      .oor_i   (above_i[b*DATA_W +: DATA_W] | below_i[b*DATA_W +: DATA_W]),
      .rd_clr_i(rd_clr),
      .mask_i  (mask_q[b*DATA_W +: DATA_W]),
      .stat_o  (stat_all[b*DATA_W +: DATA_W]),
      .mirr_o  (mirr_all[b*DATA_W +: DATA_W]),
      .new_o   (bank_new[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[b*DATA_W +: DATA_W] <= '1;
      else if (we_i && addr_i == ADDR_W'(A_MASK0 + b))
        mask_q[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  irq_ext_in #(.N(N_IRQ), .STAGES(SYNC_STAGES), .ACT_HI(IRQ_ACT_HI)) u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (irq_i),
    .en_i  (irq_en_q),
    .act_o (irq_act)
  );

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= 1'b0;
      irq_en_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_CFG1)   int_en_q <= wdata_i[CFG1_EN_BIT];
      if (addr_i == A_CHMODE) irq_en_q[N_IRQ_LO-1:0] <= wdata_i[CHMODE_LSB +: N_IRQ_LO];
      if (addr_i == A_CFG2)   irq_en_q[N_IRQ-1:N_IRQ_LO] <= wdata_i[CFG2_LSB +: N_IRQ_HI];
    end
  end

  // interrupt combine; clear silences status path until a fresh event
  assign clr_wr    = we_i && (addr_i == A_CFG1) && wdata_i[CFG1_CLR_BIT];
  assign new_evt   = |bank_new;
  assign hold_d    = new_evt ? 1'b0 : (clr_wr ? 1'b1 : hold_q);
  assign stat_pend = |(stat_all & ~mask_q);
  assign irq_pend  = |irq_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      int_q  <= int_en_q & ((stat_pend & ~hold_q) | irq_pend);
    end
  end

  assign int_o = int_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG1) rdata_o[CFG1_EN_BIT] = int_en_q;
    if (addr_i == A_CHMODE) rdata_o[CHMODE_LSB +: N_IRQ_LO] = irq_en_q[N_IRQ_LO-1:0];
    if (addr_i == A_CFG2) rdata_o[CFG2_LSB +: N_IRQ_HI] = irq_en_q[N_IRQ-1:N_IRQ_LO];
    for (int b = 0; b < N_BANK; b++) begin
      if (addr_i == ADDR_W'(A_STAT0 + b)) rdata_o = stat_all[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(A_MASK0 + b)) rdata_o = mask_q[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(A_MIRR0 + b)) rdata_o = mirr_all[b*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [N_CH-1:0]   upd_i,
  input logic [N_CH-1:0]   above_i,
  input logic [N_CH-1:0]   below_i,
  input logic [N_CH-1:0]   stat,
  input logic [N_CH-1:0]   mirr,
  input logic [N_CH-1:0]   mask,
  input logic              int_en,
  input logic              irq_pend,
  input logic              int_o
);
  logic [N_CH-1:0] hit;
  logic            clr_wr;
  assign hit    = upd_i & (above_i | below_i);
  assign clr_wr = we_i && addr_i == A_CFG1 && wdata_i[CFG1_CLR_BIT];

  p_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en |=> !int_o);

  p_clr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !re_i && upd_i == '0 |=> stat == $past(stat));

  p_rdclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_STAT0 && upd_i[DATA_W-1:0] == '0 |=> stat[DATA_W-1:0] == '0);

  p_upd_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> (stat & $past(hit)) == $past(hit));

  p_mirr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i == '0 |=> $stable(mirr));

  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat & ~mask) == '0 && !irq_pend |=> !int_o);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .upd_i   (upd_i),
  .above_i (above_i),
  .below_i (below_i),
  .stat    (stat_all),
  .mirr    (mirr_all),
  .mask    (mask_q),
  .int_en  (int_en_q),
  .irq_pend(irq_pend),
  .int_o   (int_o)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = '0, wdata_i = '0, rdata_o;
  logic        we_i = 1'b0, re_i = 1'b0, int_o;
  logic [15:0] upd_i = '0, above_i = '0, below_i = '0;
  logic [4:0]  irq_i = 5'b00111;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_status_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .upd_i(upd_i),
    .above_i(above_i), .below_i(below_i), .irq_i(irq_i), .int_o(int_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step();
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    step();
    re_i = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr_i = a; re_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [15:0] u, input logic [15:0] hi, input logic [15:0] lo);
    upd_i = u; above_i = hi; below_i = lo;
    step();
    upd_i = '0; above_i = '0; below_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 int_o", int_o, 0);
    peek(8'h40, d); chk("R11 cfg1", d, 8'h00);
    peek(8'h41, d); chk("R11 stat0", d, 8'h00);
    peek(8'h42, d); chk("R11 stat1", d, 8'h00);
    peek(8'h43, d); chk("R11 mask0", d, 8'hFF);
    peek(8'h44, d); chk("R11 mask1", d, 8'hFF);
    peek(8'h45, d); chk("R11 mirr0", d, 8'h00);
    peek(8'h46, d); chk("R11 mirr1", d, 8'h00);
    peek(8'h47, d); chk("R11 chmode", d, 8'h00);
    peek(8'h4A, d); chk("R11 cfg2", d, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] d;
    pulse(16'h0007, 16'h0201, 16'h0002);
    peek(8'h41, d); chk("R1 stat0 window", d, 8'h03);
    peek(8'h42, d); chk("R1 stat1 no strobe", d, 8'h00);
    pulse(16'h0001, 16'h0000, 16'h0000);
    peek(8'h41, d); chk("R2 sticky", d, 8'h03);
  endtask

  task automatic t_readclr();
    logic [7:0] d;
    rd(8'h41, d); chk("R3 read value", d, 8'h03);
    peek(8'h41, d); chk("R3 cleared", d, 8'h00);
    peek(8'h45, d); chk("R9 mirror kept", d, 8'h03);
    pulse(16'h0002, 16'h0000, 16'h0000);
    peek(8'h45, d); chk("R9 mirror follows update", d, 8'h01);
    rd(8'h41, d); chk("R3 stays clear", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    addr_i = 8'h42; re_i = 1'b1;
    upd_i = 16'h1000; above_i = 16'h1000;
    #1 d = rdata_o;
    chk("R4 read before", d, 8'h00);
    step();
    re_i = 1'b0; upd_i = '0; above_i = '0;
    peek(8'h42, d); chk("R4 update wins", d, 8'h10);
    rd(8'h42, d); chk("R4 readback", d, 8'h10);
  endtask

  task automatic t_mask_en();
    logic [7:0] d;
    wr(8'h40, 8'h01);
    pulse(16'h0004, 16'h0004, 16'h0000);
    step();
    chk("R5 masked", int_o, 0);
    wr(8'h43, 8'hFB);
    step();
    chk("R5 unmasked", int_o, 1);
    wr(8'h40, 8'h00);
    step();
    chk("R6 disabled", int_o, 0);
    wr(8'h40, 8'h01);
    step();
    chk("R6 enabled", int_o, 1);
    rd(8'h41, d); chk("R3 stat0", d, 8'h04);
    step();
    chk("R5 int after clear", int_o, 0);
    pulse(16'h0004, 16'h0000, 16'h0004);
    chk("R12 not yet", int_o, 0);
    step();
    chk("R12 registered", int_o, 1);
  endtask

  task automatic t_intclr();
    logic [7:0] d;
    wr(8'h40, 8'h09);
    step();
    chk("R7 int dropped", int_o, 0);
    peek(8'h41, d); chk("R7 status kept", d, 8'h04);
    peek(8'h40, d); chk("R7 clr reads 0", d, 8'h01);
    pulse(16'h0004, 16'h0004, 16'h0000);
    step(); step();
    chk("R8 old bit no reassert", int_o, 0);
    wr(8'h43, 8'hF3);
    pulse(16'h0008, 16'h0008, 16'h0000);
    step();
    chk("R8 new bit reasserts", int_o, 1);
    rd(8'h41, d); chk("R3 stat0 both", d, 8'h0C);
    step();
    chk("R8 int low after read", int_o, 0);
  endtask

  task automatic t_mirror();
    logic [7:0] d;
    rd(8'h45, d); chk("R9 mirror read 1", d, 8'h0D);
    rd(8'h45, d); chk("R9 mirror read 2", d, 8'h0D);
    wr(8'h45, 8'h00);
    peek(8'h45, d); chk("R9 mirror write ignored", d, 8'h0D);
    peek(8'h46, d); chk("R9 mirror1", d, 8'h10);
    step();
    chk("R9 mirror no int", int_o, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    irq_i[0] = 1'b0;
    repeat (4) step();
    chk("R10 pin0 not enabled", int_o, 0);
    wr(8'h47, 8'h10);
    repeat (4) step();
    chk("R10 pin0 active low", int_o, 1);
    irq_i[0] = 1'b1;
    repeat (4) step();
    chk("R10 pin0 released", int_o, 0);
    wr(8'h47, 8'h20);
    repeat (4) step();
    chk("R10 pin1 high inactive", int_o, 0);
    wr(8'h47, 8'h00);
    wr(8'h4A, 8'h80);
    irq_i[4] = 1'b1;
    repeat (4) step();
    chk("R10 pin4 active high", int_o, 1);
    irq_i[4] = 1'b0; irq_i[3] = 1'b1;
    repeat (4) step();
    chk("R10 pin3 not enabled", int_o, 0);
    peek(8'h4A, d); chk("R10 cfg2 readback", d, 8'h80);
    irq_i[3] = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_window();
    t_readclr();
    t_collide();
    t_mask_en();
    t_intclr();
    t_mirror();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule